// File: doc/BRIEF.md
# Escaped Packet Byte Stream Encoder

This block takes a payload packet as a stream of bytes on a valid/ready interface, with a marker on the last byte. It turns that packet into a framed byte stream for a serial link. Each packet starts with a three-byte header. Payload bytes that collide with a framing or link control value are replaced by a two-byte escape pair. The end-of-packet marker is placed in front of the final payload byte rather than after it. The result leaves on a second valid/ready byte stream.

A per-packet word mode selects how the stream is shaped for the link. In byte mode the framed bytes go out in order with no filler. In word mode the framed packet is brought up to a whole number of four-byte words by inserting idle filler just before the end marker. The closing bytes of the packet therefore reach the far side only at the end of the final word, so the far side cannot start its reply while filler is still being sent. Each group of four bytes is sent in reverse order, so a little-endian word goes out most significant byte first.

Top module: `esc_frame_encoder`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after it is sampled, `out_valid` and `in_ready` are low, and the block waits for the first byte of a new packet. A packet that was cut off by reset produces no more output bytes.
- R2: Every framed packet opens with 0x7A, then 0x7C, then the channel number 0x00.
- R3: A payload byte of 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R4: A payload byte of 0x4A or 0x4D is sent as 0x4D followed by the byte XOR 0x20.
- R5: The end marker 0x7B is sent immediately before the final payload byte. A one-byte packet is therefore header, 0x7B, byte.
- R6: A reserved final payload byte is escaped by the rules of R3 and R4, and its escape pair follows the end marker.
- R7: In word mode (`word_mode`=1), idle bytes 0x4A are inserted immediately before the end marker. Exactly as many are inserted as make the framed packet length a multiple of 4. When the length is already a multiple of 4, none are inserted.
- R8: In byte mode (`word_mode`=0), no filler is added and the framed bytes leave in order.
- R9: In word mode, framed bytes 4k..4k+3 leave in the order 4k+3, 4k+2, 4k+1, 4k.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. No byte is lost or repeated under backpressure.
- R11: `word_mode` is sampled when a packet's first byte is offered, and it applies to that whole packet. Back-to-back packets may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1: four-byte word mode, 0: byte mode; sampled at packet start |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a packet |
| out_valid | output | 1 | Framed byte available |
| out_ready | input | 1 | Downstream takes the framed byte |
| out_data | output | 8 | Framed byte |

## Verification
The bench drives several kinds of payload:
- Plain payloads in byte mode, which show the header and the early end marker without escape logic getting in the way.
- Payloads made entirely of the four packet-control values or the two link-control values, which tell the two escape leads apart.
- Payloads whose final byte is reserved, which separate a correct escape-after-marker tail from a naive one.
- In word mode, lengths that need zero, one or three filler bytes, which expose both the filler count and where it lands. Word mode also checks the byte reversal within each word.

Random downstream stalls, a forced long stall, back-to-back packets that alternate modes, and a reset in the middle of a packet check the flow control, the per-packet mode sampling and the restart.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;

   localparam logic [7:0] MK_SOP   = 8'h7A;
   localparam logic [7:0] MK_EOP   = 8'h7B;
   localparam logic [7:0] MK_CHAN  = 8'h7C;
   localparam logic [7:0] MK_PESC  = 8'h7D;
   localparam logic [7:0] MK_IDLE  = 8'h4A;
   localparam logic [7:0] MK_LESC  = 8'h4D;
   localparam logic [7:0] CHAN_ID  = 8'h00;
   localparam logic [7:0] ESC_FLIP = 8'h20;

   typedef enum logic [3:0] {
      FS_IDLE,
      FS_SOP,
      FS_CHM,
      FS_CHN,
      FS_BODY,
      FS_ESC2,
      FS_PAD,
      FS_EOP,
      FS_TESC,
      FS_TVAL
   } frm_state_e;

   // true for any value that must not appear raw on the link
   function automatic logic needs_escape(input logic [7:0] b);
      return (b == MK_SOP) || (b == MK_EOP) || (b == MK_CHAN) ||
             (b == MK_PESC) || (b == MK_IDLE) || (b == MK_LESC);
   endfunction

   // link-level values take the link escape, packet-level ones the packet escape
   function automatic logic [7:0] escape_lead(input logic [7:0] b);
      return ((b == MK_IDLE) || (b == MK_LESC)) ? MK_LESC : MK_PESC;
   endfunction

endpackage

// File: rtl/esc_frame_builder.sv
module esc_frame_builder
   import esc_enc_pkg::*;
#(
   parameter int WORD_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       word_mode,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       f_valid,
   input  logic       f_ready,
   output logic [7:0] f_data,
   output logic       f_first,
   output logic       f_end,
   output logic       f_wide
);

   localparam int PW = $clog2(WORD_BYTES);

   frm_state_e     st, nxt;
   logic [7:0]     hold;
   logic           hold_esc;
   logic           wide_q;
   logic [PW-1:0]  pos;
   logic [PW-1:0]  pad_q;
   logic [7:0]     tail_len;
   logic [7:0]     pad_full;
   logic [PW-1:0]  pad_calc;
   logic           in_rsv;

   assign in_rsv   = needs_escape(in_data);
   assign tail_len = in_rsv ? 8'd3 : 8'd2;
   assign pad_full = 8'd0 - 8'(pos) - tail_len;
   assign pad_calc = wide_q ? pad_full[PW-1:0] : '0;
   assign f_first  = (st == FS_SOP);
   assign f_end    = (st == FS_TVAL);
   assign f_wide   = wide_q;

   always_comb begin
      nxt      = st;
      f_valid  = 1'b0;
      f_data   = 8'h00;
      in_ready = 1'b0;
      unique case (st)
         FS_IDLE: if (in_valid) nxt = FS_SOP;
         FS_SOP: begin
            f_valid = 1'b1;
            f_data  = MK_SOP;
            if (f_ready) nxt = FS_CHM;
         end
         FS_CHM: begin
            f_valid = 1'b1;
            f_data  = MK_CHAN;
            if (f_ready) nxt = FS_CHN;
         end
         FS_CHN: begin
            f_valid = 1'b1;
            f_data  = CHAN_ID;
            if (f_ready) nxt = FS_BODY;
         end
         FS_BODY: begin
            in_ready = (in_valid && in_last) ? 1'b1 : f_ready;
            if (in_valid && !in_last) begin
               f_valid = 1'b1;
               f_data  = in_rsv ? escape_lead(in_data) : in_data;
               if (f_ready && in_rsv) nxt = FS_ESC2;
            end else if (in_valid && in_last) begin
               nxt = (pad_calc != '0) ? FS_PAD : FS_EOP;
            end
         end
         FS_ESC2: begin
            f_valid = 1'b1;
            f_data  = hold;
            if (f_ready) nxt = FS_BODY;
         end
         FS_PAD: begin
            f_valid = 1'b1;
            f_data  = MK_IDLE;
            if (f_ready && pad_q == PW'(1)) nxt = FS_EOP;
         end
         FS_EOP: begin
            f_valid = 1'b1;
            f_data  = MK_EOP;
            if (f_ready) nxt = hold_esc ? FS_TESC : FS_TVAL;
         end
         FS_TESC: begin
            f_valid = 1'b1;
            f_data  = escape_lead(hold);
            if (f_ready) nxt = FS_TVAL;
         end
         FS_TVAL: begin
            f_valid = 1'b1;
            f_data  = hold_esc ? (hold ^ ESC_FLIP) : hold;
            if (f_ready) nxt = FS_IDLE;
         end
         default: nxt = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= FS_IDLE;
         hold     <= 8'h00;
         hold_esc <= 1'b0;
         wide_q   <= 1'b0;
         pos      <= '0;
         pad_q    <= '0;
      end else begin
         st <= nxt;
         if (st == FS_IDLE) begin
            wide_q <= word_mode;
            pos    <= '0;
         end else if (f_valid && f_ready) begin
            pos <= pos + PW'(1);
         end
         if (st == FS_BODY && in_valid && in_ready) begin
            if (in_last) begin
               hold     <= in_data;
               hold_esc <= in_rsv;
               pad_q    <= pad_calc;
            end else if (in_rsv) begin
               hold <= in_data ^ ESC_FLIP;
            end
         end
         if (st == FS_PAD && f_ready) pad_q <= pad_q - PW'(1);
      end
   end

endmodule

// File: rtl/esc_word_order.sv
module esc_word_order #(
   parameter int WORD_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       f_valid,
   output logic       f_ready,
   input  logic [7:0] f_data,
   input  logic       f_wide,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data
);

   localparam int PW = $clog2(WORD_BYTES);

   logic                       draining;
   logic [PW-1:0]              idx;
   logic                       mode_q;
   logic                       mode_eff;
   logic                       wr_en;
   logic [WORD_BYTES-1:0][7:0] slot_bus;

   // mode may only change on a word boundary with nothing buffered
   assign mode_eff = (!draining && idx == '0) ? f_wide : mode_q;
   assign wr_en    = mode_eff && !draining && f_valid;

   for (genvar s = 0; s < WORD_BYTES; s++) begin : g_slot
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (rst)                              q <= 8'h00;
         else if (wr_en && idx == PW'(s))      q <= f_data;
      end
      assign slot_bus[s] = q;
   end

   always_comb begin
      if (!mode_eff) begin
         out_valid = f_valid;
         out_data  = f_data;
         f_ready   = out_ready;
      end else if (!draining) begin
         out_valid = 1'b0;
         out_data  = 8'h00;
         f_ready   = 1'b1;
      end else begin
         out_valid = 1'b1;
         out_data  = slot_bus[idx];
         f_ready   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         draining <= 1'b0;
         idx      <= '0;
         mode_q   <= 1'b0;
      end else begin
         mode_q <= mode_eff;
         if (wr_en) begin
            if (idx == PW'(WORD_BYTES - 1)) draining <= 1'b1;
            else                            idx <= idx + PW'(1);
         end else if (mode_eff && draining && out_ready) begin
            if (idx == '0) draining <= 1'b0;
            else           idx <= idx - PW'(1);
         end
      end
   end

endmodule

// File: rtl/esc_frame_encoder.sv
module esc_frame_encoder #(
   parameter int WORD_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       word_mode,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data
);

   if (WORD_BYTES < 2 || WORD_BYTES > 8 ||
       (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two between 2 and 8");
   end

   logic       f_valid;
   logic       f_ready;
   logic [7:0] f_data;
   logic       f_first;
   logic       f_end;
   logic       f_wide;

   esc_frame_builder #(.WORD_BYTES(WORD_BYTES)) i_build (
      .clk      (clk),
      .rst      (rst),
      .word_mode(word_mode),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_last  (in_last),
      .f_valid  (f_valid),
      .f_ready  (f_ready),
      .f_data   (f_data),
      .f_first  (f_first),
      .f_end    (f_end),
      .f_wide   (f_wide)
   );

   esc_word_order #(.WORD_BYTES(WORD_BYTES)) i_order (
      .clk      (clk),
      .rst      (rst),
      .f_valid  (f_valid),
      .f_ready  (f_ready),
      .f_data   (f_data),
      .f_wide   (f_wide),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
   );

endmodule

// File: rtl/esc_frame_encoder_chk.sv
module esc_frame_encoder_chk #(
   parameter int WORD_BYTES = 4
) (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_ready,
   input logic [7:0] in_data,
   input logic       in_last,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       f_valid,
   input logic       f_ready,
   input logic [7:0] f_data,
   input logic       f_first,
   input logic       f_end,
   input logic       f_wide
);

   localparam int PW = $clog2(WORD_BYTES);

   logic       rst_d = 1'b0;
   logic [7:0] cnt;
   logic       pkt_esc_in;
   logic       lnk_esc_in;

   assign pkt_esc_in = in_data inside {8'h7A, 8'h7B, 8'h7C, 8'h7D};
   assign lnk_esc_in = in_data inside {8'h4A, 8'h4D};

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst)                      cnt <= 8'd0;
      else if (f_valid && f_ready)  cnt <= f_first ? 8'd1 : cnt + 8'd1;
   end

   // R1
   always @(posedge clk) begin
      if (rst_d && !rst) begin
         r1_idle_after_reset_chk: assert (!out_valid && !in_ready);
      end
   end

   // R2
   r2_header_start_chk: assert property (@(posedge clk) disable iff (rst)
      f_valid && f_first |-> f_data == 8'h7A);

   // R3
   r3_packet_escape_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !in_last && pkt_esc_in |-> f_valid && f_data == 8'h7D);

   // R4
   r4_link_escape_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !in_last && lnk_esc_in |-> f_valid && f_data == 8'h4D);

   // R7
   r7_word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
      f_valid && f_ready && f_end && f_wide |-> cnt[PW-1:0] == PW'(WORD_BYTES - 1));

   // R10
   r10_hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

bind esc_frame_encoder esc_frame_encoder_chk #(.WORD_BYTES(WORD_BYTES)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_data  (in_data),
   .in_last  (in_last),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .f_valid  (f_valid),
   .f_ready  (f_ready),
   .f_data   (f_data),
   .f_first  (f_first),
   .f_end    (f_end),
   .f_wide   (f_wide)
);

// File: tb/test_esc_frame_encoder.sv
module test_esc_frame_encoder;

   logic       clk = 1'b0;
   logic       rst;
   logic       word_mode;
   logic       in_valid;
   logic       in_ready;
   logic [7:0] in_data;
   logic       in_last;
   logic       out_valid;
   logic       out_ready;
   logic [7:0] out_data;

   int         n_cmp = 0;
   int         n_bad = 0;
   bit         mon_en = 1'b1;
   bit         stall = 1'b0;
   bit         done = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   esc_frame_encoder i_esc_frame_encoder (
      .clk(clk), .rst(rst), .word_mode(word_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic bit is_rsv(input logic [7:0] b);
      return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D || b == 8'h4A || b == 8'h4D;
   endfunction

   function automatic logic [7:0] lead_of(input logic [7:0] b);
      return (b == 8'h4A || b == 8'h4D) ? 8'h4D : 8'h7D;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // downstream ready: random, or held low while stall is set
   always @(negedge clk) out_ready <= stall ? 1'b0 : ($urandom % 4 != 0);

   // monitor: pops expected bytes as the design hands them over
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (mon_en && !rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected byte", out_data, 8'h00);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(out_data == e, t, "stream byte", out_data, e);
            end
         end
      end
   end

   // build the expected framed stream of one packet
   task automatic push_expected(input bit wide, input logic [7:0] pl[$], input string tag);
      logic [7:0] lg[$];
      logic [7:0] tl[$];
      logic [7:0] lb;
      int         pad;
      lg = {8'h7A, 8'h7C, 8'h00};
      for (int i = 0; i < pl.size() - 1; i++) begin
         if (is_rsv(pl[i])) begin
            lg.push_back(lead_of(pl[i]));
            lg.push_back(pl[i] ^ 8'h20);
         end else begin
            lg.push_back(pl[i]);
         end
      end
      lb = pl[pl.size() - 1];
      tl.push_back(8'h7B);
      if (is_rsv(lb)) begin
         tl.push_back(lead_of(lb));
         tl.push_back(lb ^ 8'h20);
      end else begin
         tl.push_back(lb);
      end
      pad = wide ? (4 - ((lg.size() + tl.size()) % 4)) % 4 : 0;
      for (int i = 0; i < pad; i++) lg.push_back(8'h4A);
      foreach (tl[i]) lg.push_back(tl[i]);
      if (wide) begin
         for (int w = 0; w < lg.size(); w += 4)
            for (int k = 3; k >= 0; k--) begin
               exp_q.push_back(lg[w + k]);
               tag_q.push_back(tag);
            end
      end else begin
         foreach (lg[i]) begin
            exp_q.push_back(lg[i]);
            tag_q.push_back(tag);
         end
      end
   endtask

   task automatic put(input logic [7:0] b, input bit last);
      bit ok;
      in_valid = 1'b1;
      in_data  = b;
      in_last  = last;
      do begin
         #3;
         ok = in_ready;
         @(negedge clk);
      end while (!ok);
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input string tag, input bit wide, input logic [7:0] pl[$]);
      push_expected(wide, pl, tag);
      word_mode = wide;
      foreach (pl[i]) put(pl[i], i == pl.size() - 1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done (queue %0d)", exp_q.size());
         report();
      end
   end

   initial begin
      rst = 1'b1;
      word_mode = 1'b0;
      in_valid = 1'b0;
      in_data = 8'h00;
      in_last = 1'b0;
      repeat (3) @(negedge clk);
      #3;
      chk(!out_valid && !in_ready, "R1", "idle in reset", {6'd0, out_valid, in_ready}, 8'h00);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #3;
      chk(!out_valid && !in_ready, "R1", "idle after reset", {6'd0, out_valid, in_ready}, 8'h00);
      @(negedge clk);

      // R2 R5 R8: plain bytes, byte mode
      send_pkt("R8", 1'b0, '{8'h01, 8'h02, 8'h03, 8'h04});
      // R3: packet-level reserved values
      send_pkt("R3", 1'b0, '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h55});
      // R4: link-level reserved values
      send_pkt("R4", 1'b0, '{8'h4A, 8'h4D, 8'h11});
      // R6: reserved last byte
      send_pkt("R6", 1'b0, '{8'h10, 8'h7B});
      // R5: one-byte packet, and one-byte reserved packet
      send_pkt("R5", 1'b0, '{8'h33});
      send_pkt("R6", 1'b0, '{8'h4A});
      // R7 R9: word mode needing three filler bytes
      send_pkt("R7", 1'b1, '{8'h10, 8'h00, 8'h00, 8'h04, 8'h02, 8'h4B, 8'h7A, 8'h40});
      // R7: already aligned, no filler
      send_pkt("R7", 1'b1, '{8'hA1, 8'hA2, 8'hA3, 8'hA4});
      // R9: word mode, reserved last byte
      send_pkt("R9", 1'b1, '{8'h20, 8'h4D});
      // R7: one filler byte
      send_pkt("R7", 1'b1, '{8'h01, 8'h02, 8'h03});
      // R11: back-to-back alternating modes
      send_pkt("R11", 1'b1, '{8'h5A, 8'h7C});
      send_pkt("R11", 1'b0, '{8'h66, 8'h67, 8'h68});
      send_pkt("R11", 1'b1, '{8'h4A, 8'h00, 8'h7D});

      // R10: long forced stall in word mode
      while (exp_q.size() != 0) @(negedge clk);
      stall = 1'b1;
      fork
         begin
            logic       v0;
            logic [7:0] d0;
            repeat (8) @(negedge clk);
            #3;
            v0 = out_valid;
            d0 = out_data;
            repeat (6) @(negedge clk);
            #3;
            chk(v0 && out_valid && out_data == d0, "R10", "held under stall", out_data, d0);
            @(negedge clk);
            stall = 1'b0;
         end
      join_none
      send_pkt("R10", 1'b1, '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4});

      // random payloads, both modes
      for (int p = 0; p < 12; p++) begin
         logic [7:0] pl[$];
         int         n;
         n = 1 + ($urandom % 9);
         for (int i = 0; i < n; i++) begin
            case ($urandom % 4)
               0: pl.push_back(8'h7A + 8'($urandom % 4));
               1: pl.push_back(($urandom % 2) ? 8'h4A : 8'h4D);
               default: pl.push_back(8'($urandom));
            endcase
         end
         send_pkt((p % 2) ? "R3" : "R4", 1'(p % 2), pl);
      end

      // R1: reset in the middle of a packet, then restart
      while (exp_q.size() != 0) @(negedge clk);
      mon_en = 1'b0;
      word_mode = 1'b1;
      put(8'h11, 1'b0);
      put(8'h22, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      #3;
      chk(!out_valid && !in_ready, "R1", "idle after mid-packet reset", {6'd0, out_valid, in_ready}, 8'h00);
      @(negedge clk);
      mon_en = 1'b1;
      send_pkt("R1", 1'b0, '{8'h91, 8'h92});

      while (exp_q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      done = 1'b1;
      report();
   end

endmodule